// File: doc/BRIEF.md
# Page-Safe EEPROM Write Segmenter

This block accepts one write request for a serial EEPROM: a linear 17-bit start address, a byte count and a stream of data bytes. It cuts the request into write transactions that a separate two-wire bus master carries out. No transaction runs past the end of a 128-byte page. No transaction runs past the end of either 64 KiB half of the array.

For each piece the block issues a header command to the bus master. The header holds the device control byte, the 16-bit word address inside the selected half, and the piece length. The control byte carries the half-select bit and two chip-select bits. The block then forwards exactly that many data bytes from its input stream to the master.

When the master reports that the write transaction has ended, the block sends control-byte-only probes. It repeats the probe until the device acknowledges, which means the internal write cycle is finished. Only then does it send the next piece. The programmed probe limit is set by the user so that it covers the worst-case 5 ms write cycle. If the device still has not acknowledged when that limit is reached, the request is abandoned and the failing piece's start address is reported.

Top module: `eeprom_wr_splitter`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle: req_ready=1, busy=0, cmd_valid=0, out_valid=0, in_ready=0, done=0, err=0.
- R2: Each header's cmd_len equals the smallest of three values: the bytes still to write, 128 minus (address mod 128), and 65536 minus (address mod 65536). It is never zero.
- R3: cmd_ctrl is {4'b1010, address bit 16, cs[1], cs[0], 1'b0}, with cs captured when the request is accepted. cmd_waddr is address bits 15:0. Probes (cmd_probe=1) carry the same control byte as the piece they follow.
- R4: During a piece, exactly cmd_len bytes pass from in_data to out_data in order and unchanged. in_ready and out_valid stay low while a command is pending and while waiting or probing.
- R5: After the master's response that ends a write (rsp_valid), the block issues a probe. A response with rsp_ack=0 causes another probe. A response with rsp_ack=1 starts the next piece or finishes the request.
- R6: When the number of rejected probes for one piece reaches poll_limit (a limit of 0 acts as 1), the request stops. err goes high, err_addr holds that piece's start address, and done pulses. err stays high until the next request is accepted.
- R7: busy is high from the cycle after a non-empty request is accepted. done is a one-cycle pulse in the cycle after the final accepting probe response, and busy is low from that same cycle.
- R8: A request is taken only when req_ready=1, which is exactly when the block is idle. req_valid asserted while busy has no effect on the commands issued.
- R9: A request of length 0 produces done one cycle after acceptance, with no command and busy staying low.
- R10: After the last byte of the upper half (0x1FFFF), the next piece starts at address 0x00000 with half-select 0.
- R11: While cmd_valid=1 and cmd_ready=0, cmd_valid stays high and cmd_probe, cmd_ctrl, cmd_waddr and cmd_len hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | 17 | Linear start address |
| req_len | input | 18 | Byte count, 0 to 131072 |
| req_cs | input | 2 | Chip-select bits for the control byte |
| poll_limit | input | 16 | Maximum rejected probes per piece |
| in_valid | input | 1 | Input data byte valid |
| in_ready | output | 1 | Input data byte accepted |
| in_data | input | 8 | Input data byte |
| cmd_valid | output | 1 | Command to bus master valid |
| cmd_ready | input | 1 | Bus master takes the command |
| cmd_probe | output | 1 | 1 = control-byte-only probe, 0 = write header |
| cmd_ctrl | output | 8 | Device control byte |
| cmd_waddr | output | 16 | Word address within the half |
| cmd_len | output | 8 | Piece length (0 for a probe) |
| out_valid | output | 1 | Data byte to bus master valid |
| out_ready | input | 1 | Bus master takes the data byte |
| out_data | output | 8 | Data byte to bus master |
| rsp_valid | input | 1 | Bus master transaction finished |
| rsp_ack | input | 1 | Device acknowledged the probe |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Last request stopped on probe limit |
| err_addr | output | 17 | Start address of the failing piece |

## Verification
A header appears in the cycle after acceptance or after the previous accepting probe response. The first probe appears in the cycle after the write-end response. done, err and err_addr change in the cycle after the deciding probe response. The bench drives every input on the falling edge and samples a short settle time later. It therefore reads registered results one falling edge after the rising edge that produced them, and reads pass-through data in the same half cycle that it offers the handshake. Write-end responses are issued two or more falling edges after the last data byte, so the block has already left its data phase.

// File: rtl/eews_pkg.sv
package eews_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_WEND,
    ST_PROBE,
    ST_PRSP
  } seg_state_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // Control byte: device type, half select, chip select, write direction.
  function automatic logic [7:0] ctrl_byte(input logic half, input logic [1:0] cs);
    return {DEV_TYPE, half, cs, 1'b0};
  endfunction

endpackage

// File: rtl/eews_chunk.sv
module eews_chunk #(
  parameter int ADDR_W     = 17,
  parameter int LEN_W      = ADDR_W + 1,
  parameter int PAGE_BYTES = 128,
  parameter int CL_W       = $clog2(PAGE_BYTES) + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  rem,
  output logic [CL_W-1:0]   len
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam logic [LEN_W-1:0] PAGE_SZ = LEN_W'(PAGE_BYTES);
  localparam logic [LEN_W-1:0] HALF_SZ = LEN_W'(1) << (ADDR_W - 1);

  logic [LEN_W-1:0] page_left, half_left, m1, m2;

  always_comb begin
    page_left = PAGE_SZ - LEN_W'(addr[PAGE_W-1:0]);
    half_left = HALF_SZ - LEN_W'(addr[ADDR_W-2:0]);
    m1        = (rem < page_left) ? rem : page_left;
    m2        = (m1 < half_left) ? m1 : half_left;
    len       = CL_W'(m2);
  end

endmodule

// File: rtl/eews_gate.sv
module eews_gate #(
  parameter int CL_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CL_W-1:0]   load_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              fin
);
  logic [CL_W-1:0] left_q, left_d;
  logic            open, fire, left_en;

  assign open      = (left_q != '0);
  assign out_valid = in_valid & open;
  assign in_ready  = out_ready & open;
  assign out_data  = in_data;
  assign fire      = in_valid & out_ready & open;
  assign fin       = ~open;
  assign left_en   = load | fire;

  always_comb begin
    left_d = left_q;
    if (load)      left_d = load_len;
    else if (fire) left_d = left_q - CL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  // R4: every forwarded byte consumes one unit of the piece budget
  a_r4_gate_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> (left_q < $past(left_q)));

endmodule

// File: rtl/eeprom_wr_splitter.sv
module eeprom_wr_splitter #(
  parameter int ADDR_W     = 17,
  parameter int LEN_W      = ADDR_W + 1,
  parameter int PAGE_BYTES = 128,
  parameter int PCNT_W     = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_cs,
  input  logic [PCNT_W-1:0] poll_limit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_probe,
  output logic [7:0]        cmd_ctrl,
  output logic [ADDR_W-2:0] cmd_waddr,
  output logic [$clog2(PAGE_BYTES):0] cmd_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] err_addr
);
  import eews_pkg::*;

  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CL_W   = PAGE_W + 1;

  seg_state_t        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d, eaddr_q, eaddr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [1:0]        cs_q, cs_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [PCNT_W:0]   pnext;
  logic              done_d, err_q, err_d;
  logic [CL_W-1:0]   chunk_len;
  logic              gate_load, gate_fin;

  eews_chunk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .CL_W(CL_W)
  ) u_chunk (
    .addr(addr_q), .rem(rem_q), .len(chunk_len)
  );

  assign gate_load = (st_q == ST_HDR) && cmd_ready;

  eews_gate #(.CL_W(CL_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .load(gate_load), .load_len(chunk_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fin(gate_fin)
  );

  assign busy      = (st_q != ST_IDLE);
  assign req_ready = ~busy;
  assign cmd_valid = (st_q == ST_HDR) || (st_q == ST_PROBE);
  assign cmd_probe = (st_q == ST_PROBE);
  assign cmd_ctrl  = ctrl_byte(addr_q[ADDR_W-1], cs_q);
  assign cmd_waddr = addr_q[ADDR_W-2:0];
  assign cmd_len   = cmd_probe ? '0 : chunk_len;
  assign err       = err_q;
  assign err_addr  = eaddr_q;
  assign pnext     = {1'b0, pcnt_q} + (PCNT_W+1)'(1);

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    cs_d    = cs_q;
    pcnt_d  = pcnt_q;
    done_d  = 1'b0;
    err_d   = err_q;
    eaddr_d = eaddr_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        addr_d = req_addr;
        rem_d  = req_len;
        cs_d   = req_cs;
        err_d  = 1'b0;
        if (req_len == '0) done_d = 1'b1;
        else               st_d   = ST_HDR;
      end
      ST_HDR:   if (cmd_ready) st_d = ST_DATA;
      ST_DATA:  if (gate_fin)  st_d = ST_WEND;
      ST_WEND:  if (rsp_valid) begin
        st_d   = ST_PROBE;
        pcnt_d = '0;
      end
      ST_PROBE: if (cmd_ready) st_d = ST_PRSP;
      ST_PRSP:  if (rsp_valid) begin
        if (rsp_ack) begin
          addr_d = addr_q + ADDR_W'(chunk_len);
          rem_d  = rem_q - LEN_W'(chunk_len);
          if (rem_q == LEN_W'(chunk_len)) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d = ST_HDR;
          end
        end else if (pnext >= {1'b0, poll_limit}) begin
          st_d    = ST_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
          eaddr_d = addr_q;
        end else begin
          pcnt_d = pnext[PCNT_W-1:0];
          st_d   = ST_PROBE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      cs_q    <= '0;
      pcnt_q  <= '0;
      done    <= 1'b0;
      err_q   <= 1'b0;
      eaddr_q <= '0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      cs_q    <= cs_d;
      pcnt_q  <= pcnt_d;
      done    <= done_d;
      err_q   <= err_d;
      eaddr_q <= eaddr_d;
    end
  end

  // R11: command fields hold until the master takes them
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_probe) &&
      $stable(cmd_ctrl) && $stable(cmd_waddr) && $stable(cmd_len)));

  // R2: a header never runs past its page end and is never empty
  a_r2_chunk_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_probe) |->
      (cmd_len != '0 && (int'(cmd_waddr[PAGE_W-1:0]) + int'(cmd_len)) <= PAGE_BYTES));

  // R4: no input byte is taken while a command is pending
  a_r4_no_input_while_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !in_ready);

  // R6: an error is always reported together with done
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  // R7: done is only seen once the block is idle again
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/eeprom_wr_splitter_tb.sv
module eeprom_wr_splitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 2;

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [16:0] req_addr;
  logic [17:0] req_len;
  logic [1:0]  req_cs;
  logic [15:0] poll_limit;
  logic        in_valid, in_ready;
  logic [7:0]  in_data;
  logic        cmd_valid, cmd_ready, cmd_probe;
  logic [7:0]  cmd_ctrl;
  logic [15:0] cmd_waddr;
  logic [7:0]  cmd_len;
  logic        out_valid, out_ready;
  logic [7:0]  out_data;
  logic        rsp_valid, rsp_ack;
  logic        busy, done, err;
  logic [16:0] err_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int feed_idx = 0;
  int exp_idx = 0;

  eeprom_wr_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_cs(req_cs), .poll_limit(poll_limit),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_probe(cmd_probe),
    .cmd_ctrl(cmd_ctrl), .cmd_waddr(cmd_waddr), .cmd_len(cmd_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .busy(busy), .done(done),
    .err(err), .err_addr(err_addr)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic int chunk_of(input int a, input int r);
    int pl, hl, m;
    pl = 128 - (a % 128);
    hl = 65536 - (a % 65536);
    m = (r < pl) ? r : pl;
    return (m < hl) ? m : hl;
  endfunction

  function automatic logic [7:0] exp_ctrl(input int a, input int cs);
    return {4'b1010, 1'(a >> 16), 2'(cs), 1'b0};
  endfunction

  assign in_data = pat(feed_idx);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // input byte source
  initial begin
    bit hs;
    in_valid = 1'b0;
    forever begin
      @(negedge clk);
      in_valid = ($urandom % 4) != 0;
      #SETTLE;
      hs = in_valid && in_ready;
      @(posedge clk);
      if (hs) feed_idx++;
    end
  end

  task automatic wait_cmd();
    do begin
      @(negedge clk);
      #SETTLE;
    end while (!cmd_valid);
  endtask

  task automatic take_cmd();
    logic [7:0] c0, l0;
    logic [15:0] w0;
    logic p0;
    int n;
    c0 = cmd_ctrl; l0 = cmd_len; w0 = cmd_waddr; p0 = cmd_probe;
    n = $urandom % 3;
    repeat (n) begin
      @(negedge clk);
      #SETTLE;
      chk(cmd_valid && cmd_ctrl == c0 && cmd_len == l0 && cmd_waddr == w0 && cmd_probe == p0,
          "R11 command held", {cmd_ctrl, cmd_len, cmd_waddr}, {c0, l0, w0});
    end
    cmd_ready = 1'b1;
    @(posedge clk);
    #1 cmd_ready = 1'b0;
  endtask

  task automatic run_req(input int a0, input int len, input int cs, input int lim,
                         input int err_chunk, input bit ghost, input int nack_max);
    int a, r, c, ci, nk, k;
    @(negedge clk);
    #SETTLE;
    chk(req_ready == 1'b1, "R8 ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_addr = 17'(a0); req_len = 18'(len);
    req_cs = 2'(cs); poll_limit = 16'(lim);
    @(negedge clk);
    req_valid = ghost;
    req_addr = 17'(a0 ^ 17'h0A5A5); req_len = 18'd7; req_cs = 2'(~cs);
    #SETTLE;
    if (len == 0) begin
      chk(done == 1'b1 && busy == 1'b0, "R9 empty request done", {done, busy}, 2'b10);
      repeat (3) begin
        @(negedge clk);
        #SETTLE;
        chk(!cmd_valid && !done && !busy, "R9 no command", {cmd_valid, done, busy}, 0);
      end
      return;
    end
    chk(busy == 1'b1 && err == 1'b0, "R7 busy after accept / R6 err cleared", {busy, err}, 2'b10);
    a = a0; r = len; ci = 0;
    while (r > 0) begin
      c = chunk_of(a, r);
      wait_cmd();
      chk(cmd_probe == 1'b0 && cmd_len == 8'(c), "R2 piece length", 32'(cmd_len), 32'(c));
      chk(cmd_ctrl == exp_ctrl(a, cs) && cmd_waddr == 16'(a),
          "R3 R10 control byte and word address", {cmd_ctrl, cmd_waddr}, {exp_ctrl(a, cs), 16'(a)});
      chk(req_ready == 1'b0 && done == 1'b0, "R8 not ready while busy", {req_ready, done}, 0);
      if (ghost && r == c) req_valid = 1'b0;
      take_cmd();
      k = 0;
      while (k < c) begin
        @(negedge clk);
        out_ready = ($urandom % 3) != 0;
        #SETTLE;
        if (out_valid && out_ready) begin
          chk(out_data == pat(exp_idx), "R4 data byte", 32'(out_data), 32'(pat(exp_idx)));
          exp_idx++;
          k++;
        end
        @(posedge clk);
      end
      #1 out_ready = 1'b0;
      repeat (2 + ($urandom % 2)) @(negedge clk);
      #SETTLE;
      chk(out_valid == 1'b0 && in_ready == 1'b0, "R4 no extra byte", {out_valid, in_ready}, 0);
      rsp_valid = 1'b1; rsp_ack = 1'b1;
      @(negedge clk);
      rsp_valid = 1'b0;
      nk = (ci == err_chunk) ? ((lim == 0) ? 1 : lim) : int'($urandom % (nack_max + 1));
      for (int p = 0; p <= nk; p++) begin
        if (ci == err_chunk && p == nk) break;
        wait_cmd();
        chk(cmd_probe == 1'b1 && cmd_ctrl == exp_ctrl(a, cs) && in_ready == 1'b0,
            "R5 R3 probe", {cmd_probe, cmd_ctrl, in_ready}, {1'b1, exp_ctrl(a, cs), 1'b0});
        take_cmd();
        @(negedge clk);
        rsp_valid = 1'b1;
        rsp_ack = (p == nk);
        @(negedge clk);
        rsp_valid = 1'b0;
        #SETTLE;
        if (p < nk && !(ci == err_chunk && p == nk - 1))
          chk(done == 1'b0 && busy == 1'b1, "R5 keep polling", {done, busy}, 2'b01);
      end
      if (ci == err_chunk) begin
        chk(err == 1'b1 && done == 1'b1 && err_addr == 17'(a), "R6 poll limit error",
            {err, done, err_addr}, {2'b11, 17'(a)});
        @(negedge clk);
        #SETTLE;
        chk(done == 1'b0 && err == 1'b1 && busy == 1'b0, "R6 error held", {done, err, busy}, 3'b010);
        return;
      end
      if (r == c) begin
        chk(done == 1'b1 && busy == 1'b0 && err == 1'b0, "R7 done pulse", {done, busy, err}, 3'b100);
        @(negedge clk);
        #SETTLE;
        chk(done == 1'b0, "R7 done one cycle", 32'(done), 0);
      end else begin
        chk(done == 1'b0, "R7 no early done", 32'(done), 0);
      end
      a = (a + c) % 131072;
      r = r - c;
      ci++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_cs = '0;
    poll_limit = 16'd8; cmd_ready = 1'b0; out_ready = 1'b0;
    rsp_valid = 1'b0; rsp_ack = 1'b0;
    repeat (3) @(negedge clk);
    #SETTLE;
    chk(req_ready && !busy && !cmd_valid && !out_valid && !in_ready && !done && !err,
        "R1 reset state", {req_ready, busy, cmd_valid, out_valid, in_ready, done, err}, 7'b1000000);
    rst_n = 1'b1;
    @(negedge clk);
    #SETTLE;
    chk(req_ready && !busy && !cmd_valid && !done, "R1 idle after reset",
        {req_ready, busy, cmd_valid, done}, 4'b1000);

    run_req(17'h00010, 5, 2, 8, -1, 0, 2);    // single piece
    run_req(17'h0007E, 6, 1, 8, -1, 0, 2);    // R2 page split 2 + 4
    run_req(17'h0FFF0, 40, 3, 8, -1, 0, 1);   // R2 half split, half bit 0 -> 1
    run_req(17'h1FFF8, 20, 0, 8, -1, 0, 1);   // R10 wrap to 0x00000
    run_req(17'h00100, 300, 2, 8, -1, 0, 3);  // full pages 128, 128, 44
    run_req(17'h00040, 0, 1, 8, -1, 0, 0);    // R9 empty
    run_req(17'h00200, 200, 1, 3, 1, 0, 2);   // R6 error on second piece at 0x00280
    run_req(17'h00050, 100, 1, 8, -1, 1, 2);  // R8 requests while busy ignored
    run_req(17'h13300, 10, 3, 0, 0, 0, 0);    // R6 limit 0 acts as 1
    for (int i = 0; i < 12; i++)
      run_req(int'($urandom % 131072), 1 + int'($urandom % 260), int'($urandom % 4), 4, -1, 0, 3);

    finished = 1;
    summary();
    $finish;
  end

endmodule